// File: doc/BRIEF.md
# Serial Port Control, Status and Interrupt Unit

This block holds the control word and the status flags of a serial port that can run in asynchronous or clocked mode, and it raises the port's two receive interrupts. A processor reaches it through a small register interface of four addresses: a control word, a status word, a transmit data register and a receive data register. The shift-register datapath sits beside the block. It exchanges single-cycle strobes with the block: it takes the next transmit byte, delivers a received byte together with its framing, parity and address-marker bits, and watches a start request that the block raises while a transmit byte is pending.

Each status flag can only be cleared by a two-step sequence. Software first reads the status word while the flag is 1, and then writes a 0 to that flag's bit position. Hardware events set flags. Turning the transmitter off pins the transmit-empty flag at 1. Turning the receiver off leaves every receive flag untouched. One enable bit gates both the receive-full interrupt and the receive-error interrupt. In asynchronous address-filtering mode, bytes that lack the address marker are dropped until a marked byte arrives.

Top module: `serial_ctl_top`

## Requirements
- R1: Register map: address 0 is the control word (bit0 txEn, bit1 rxEn, bit2 rxIrqEn, bit3 mpIrqEn, bit4 syncMode, bit5 mpMode). Address 1 is the status word (bit0 txEmpty, bit1 rxFull, bit2 frameErr, bit3 parityErr, bit4 overrun). Address 2 is transmit data and address 3 is receive data. Reads are combinational. After reset, control reads 0x00, status reads 0x01, receive data reads 0x00 and all outputs are low.
- R2: rxFullIrq is high exactly while rxFull and rxIrqEn are both 1. rxErrIrq is high exactly while rxIrqEn is 1 and at least one of frameErr, parityErr or overrun is 1. Clearing the flag or writing rxIrqEn to 0 removes the request.
- R3: A status write with a 0 in a flag's bit clears that flag only if a status read since the flag was last set saw it at 1. A 0 with no such read leaves the flag as it is, and a 1 never changes a flag.
- R4: While txEn is 0, txEmpty reads 1. This includes the case where txEn is turned off while a byte is pending, and the case where software tries to clear txEmpty.
- R5: txStart is high while txEn is 1 and txEmpty is 0. The clock edge that samples txLoad sets txEmpty to 1. txByte always shows the last value written to address 2.
- R6: A byte that rxValid delivers while rxEn is 1 and rxFull is 0 is stored in receive data and sets rxFull. The same edge sets frameErr and parityErr when the matching input bit is 1.
- R7: A byte accepted while rxFull is 1 sets overrun. Receive data keeps the earlier byte and rxFull stays 1.
- R8: While rxEn is 0, rxValid is ignored. Writing rxEn to 0 leaves rxFull, frameErr, parityErr and overrun unchanged.
- R9: Address filtering is active when syncMode is 0, mpMode is 1 and mpIrqEn is 1. While it is active, a byte with rxMpBit 0 is dropped without touching any flag or data. A byte with rxMpBit 1 is accepted and clears mpIrqEn. In any other mode, mpIrqEn has no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe; a status read arms flags for clearing |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for busAddr |
| txByte | output | DATA_W | Transmit byte offered to the datapath |
| txStart | output | 1 | A transmit byte is pending |
| txLoad | input | 1 | Datapath has taken txByte |
| rxValid | input | 1 | Datapath delivers a received byte |
| rxByte | input | DATA_W | Received byte |
| rxFrameErr | input | 1 | Stop-bit error on the delivered byte |
| rxParityErr | input | 1 | Parity error on the delivered byte |
| rxMpBit | input | 1 | Address marker of the delivered byte |
| rxFullIrq | output | 1 | Receive-full interrupt request |
| rxErrIrq | output | 1 | Receive-error interrupt request |

## Verification
The properties assume that the datapath strobes txLoad and rxValid last one cycle and that the bus never writes status and control in the same cycle. They also assume that a control write never coincides with a marked byte that wakes the address filter. The bench keeps to these rules by driving every input on the falling edge, issuing one bus operation or one datapath strobe at a time, and releasing it on the next falling edge. It samples outputs one nanosecond after a falling edge, where only register state feeds them.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_STAT   = 2'd1,
    ADDR_TXDATA = 2'd2,
    ADDR_RXDATA = 2'd3
  } regAddr_e;

  // control word, bit 0 = txEn
  typedef struct packed {
    logic mpMode;
    logic syncMode;
    logic mpIrqEn;
    logic rxIrqEn;
    logic rxEn;
    logic txEn;
  } ctrl_t;

  // status word, bit 0 = txEmpty
  typedef struct packed {
    logic overrun;
    logic parityErr;
    logic frameErr;
    logic rxFull;
    logic txEmpty;
  } flags_t;

  localparam int CTRL_W    = $bits(ctrl_t);
  localparam int NUM_FLAGS = $bits(flags_t);

  localparam int ST_TXEMPTY = 0;
  localparam int ST_RXFULL  = 1;
  localparam int ST_FRAME   = 2;
  localparam int ST_PARITY  = 3;
  localparam int ST_OVERRUN = 4;

  // strobes from control to the data registers
  typedef struct packed {
    logic rxStore;
    logic txWrite;
  } dataStb_t;

endpackage

// File: rtl/serial_ctl_flagbit.sv
module serial_ctl_flagbit #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic setEv,
  input  logic forceSet,
  input  logic rdStat,
  input  logic wrStat,
  input  logic wrBit,
  output logic flagQ
);

  logic armQ;
  logic clrHit;
  logic flagNext;
  logic armNext;

  always_comb begin
    clrHit   = wrStat && !wrBit && armQ;
    flagNext = forceSet || setEv || (flagQ && !clrHit);
    if (rdStat) armNext = flagQ;
    else        armNext = armQ && !clrHit && flagNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= RESET_VAL;
      armQ  <= 1'b0;
    end else begin
      flagQ <= flagNext;
      armQ  <= armNext;
    end
  end

endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import serial_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [CTRL_W-1:0]    ctrlWrData,
  input  logic [NUM_FLAGS-1:0] statWrData,
  input  logic                 txLoad,
  input  logic                 rxValid,
  input  logic                 rxFrameErr,
  input  logic                 rxParityErr,
  input  logic                 rxMpBit,
  output ctrl_t                ctrlQ,
  output flags_t               flagQ,
  output dataStb_t             dataStb
);

  logic wrCtrl, wrStat, rdStat, wrTx;
  logic mpFilter, rxTake, rxStore, rxOver, mpWake;
  ctrl_t ctrlNext;
  logic [NUM_FLAGS-1:0] hwSet;
  logic [NUM_FLAGS-1:0] forceSet;
  logic [NUM_FLAGS-1:0] flagVec;

  always_comb begin
    wrCtrl = busWrEn && (busAddr == ADDR_CTRL);
    wrStat = busWrEn && (busAddr == ADDR_STAT);
    wrTx   = busWrEn && (busAddr == ADDR_TXDATA);
    rdStat = busRdEn && (busAddr == ADDR_STAT);
  end

  // receive acceptance with address filtering
  always_comb begin
    mpFilter = !ctrlQ.syncMode && ctrlQ.mpMode && ctrlQ.mpIrqEn;
    rxTake   = rxValid && ctrlQ.rxEn && (!mpFilter || rxMpBit);
    rxStore  = rxTake && !flagQ.rxFull;
    rxOver   = rxTake && flagQ.rxFull;
    mpWake   = rxTake && mpFilter;
  end

  always_comb begin
    ctrlNext = ctrlQ;
    if (wrCtrl) ctrlNext = ctrl_t'(ctrlWrData);
    if (mpWake) ctrlNext.mpIrqEn = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlNext;
  end

  always_comb begin
    hwSet              = '0;
    hwSet[ST_TXEMPTY]  = txLoad;
    hwSet[ST_RXFULL]   = rxStore;
    hwSet[ST_FRAME]    = rxStore && rxFrameErr;
    hwSet[ST_PARITY]   = rxStore && rxParityErr;
    hwSet[ST_OVERRUN]  = rxOver;
    forceSet             = '0;
    forceSet[ST_TXEMPTY] = !ctrlNext.txEn;
  end

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      serial_ctl_flagbit #(
        .RESET_VAL(1'(i == ST_TXEMPTY))
      ) flag_i (
        .clk     (clk),
        .rstN    (rstN),
        .setEv   (hwSet[i]),
        .forceSet(forceSet[i]),
        .rdStat  (rdStat),
        .wrStat  (wrStat),
        .wrBit   (statWrData[i]),
        .flagQ   (flagVec[i])
      );
    end
  endgenerate

  assign flagQ = flags_t'(flagVec);

  always_comb begin
    dataStb.rxStore = rxStore;
    dataStb.txWrite = wrTx;
  end

endmodule

// File: rtl/serial_ctl_data.sv
module serial_ctl_data
  import serial_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dataStb_t          dataStb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] txByteQ,
  output logic [DATA_W-1:0] rxDataQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByteQ <= '0;
      rxDataQ <= '0;
    end else begin
      if (dataStb.txWrite) txByteQ <= busWrData;
      if (dataStb.rxStore) rxDataQ <= rxByte;
    end
  end

endmodule

// File: rtl/serial_ctl_top.sv
module serial_ctl_top
  import serial_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] txByte,
  output logic              txStart,
  input  logic              txLoad,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  input  logic              rxMpBit,
  output logic              rxFullIrq,
  output logic              rxErrIrq
);

  ctrl_t             ctrlQ;
  flags_t            flagQ;
  dataStb_t          dataStb;
  logic [DATA_W-1:0] rxDataQ;

  serial_ctl_regs regs_i (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .ctrlWrData (busWrData[CTRL_W-1:0]),
    .statWrData (busWrData[NUM_FLAGS-1:0]),
    .txLoad     (txLoad),
    .rxValid    (rxValid),
    .rxFrameErr (rxFrameErr),
    .rxParityErr(rxParityErr),
    .rxMpBit    (rxMpBit),
    .ctrlQ      (ctrlQ),
    .flagQ      (flagQ),
    .dataStb    (dataStb)
  );

  serial_ctl_data #(.DATA_W(DATA_W)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .dataStb  (dataStb),
    .busWrData(busWrData),
    .rxByte   (rxByte),
    .txByteQ  (txByte),
    .rxDataQ  (rxDataQ)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL:   busRdData = DATA_W'(ctrlQ);
      ADDR_STAT:   busRdData = DATA_W'(flagQ);
      ADDR_TXDATA: busRdData = txByte;
      default:     busRdData = rxDataQ;
    endcase
  end

  always_comb begin
    txStart   = ctrlQ.txEn && !flagQ.txEmpty;
    rxFullIrq = ctrlQ.rxIrqEn && flagQ.rxFull;
    rxErrIrq  = ctrlQ.rxIrqEn && (flagQ.frameErr || flagQ.parityErr || flagQ.overrun);
  end

endmodule

// File: rtl/serial_ctl_sva.sv
module serial_ctl_sva
  import serial_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [NUM_FLAGS-1:0] statWr,
  input logic                 txLoad,
  input logic                 rxValid,
  input logic [DATA_W-1:0]    rxByte,
  input logic                 rxMpBit,
  input logic                 rxFullIrq,
  input logic                 rxErrIrq,
  input ctrl_t                ctrlQ,
  input flags_t               flagQ,
  input logic [DATA_W-1:0]    rxDataQ
);

  logic                 filterOn;
  logic                 accepted;
  logic                 statWrite;
  logic [NUM_FLAGS-1:0] flagBits;

  always_comb begin
    filterOn  = !ctrlQ.syncMode && ctrlQ.mpMode && ctrlQ.mpIrqEn;
    accepted  = rxValid && ctrlQ.rxEn && (!filterOn || rxMpBit);
    statWrite = busWrEn && (busAddr == ADDR_STAT);
    flagBits  = flagQ;
  end

  assert_irq_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.rxIrqEn |-> (!rxFullIrq && !rxErrIrq));

  assert_write_one_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && ((statWr & flagBits) == flagBits)) |=> ((flagBits & $past(flagBits)) == $past(flagBits)));

  assert_rxfull_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ.rxFull && !statWrite) |=> flagQ.rxFull);

  assert_txempty_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.txEn |-> flagQ.txEmpty);

  assert_load_sets_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> flagQ.txEmpty);

  assert_store_byte_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !flagQ.rxFull) |=> (flagQ.rxFull && rxDataQ == $past(rxByte)));

  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && flagQ.rxFull) |=> (flagQ.overrun && $stable(rxDataQ)));

  assert_rx_off_ignores_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !ctrlQ.rxEn && !flagQ.rxFull) |=> !flagQ.rxFull);

  assert_unmarked_dropped_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && ctrlQ.rxEn && filterOn && !rxMpBit && !flagQ.rxFull) |=> !flagQ.rxFull);

endmodule

bind serial_ctl_top serial_ctl_sva #(.DATA_W(DATA_W)) sva_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .statWr   (busWrData[serial_ctl_pkg::NUM_FLAGS-1:0]),
  .txLoad   (txLoad),
  .rxValid  (rxValid),
  .rxByte   (rxByte),
  .rxMpBit  (rxMpBit),
  .rxFullIrq(rxFullIrq),
  .rxErrIrq (rxErrIrq),
  .ctrlQ    (ctrlQ),
  .flagQ    (flagQ),
  .rxDataQ  (rxDataQ)
);

// File: tb/serial_ctl_top_tb_top.sv
`timescale 1ns/1ps
module serial_ctl_top_tb_top;

  localparam int DATA_W = 8;
  localparam int NVEC   = 56;

  localparam logic [2:0] OP_WR   = 3'd0;
  localparam logic [2:0] OP_RD   = 3'd1;
  localparam logic [2:0] OP_RX   = 3'd2;
  localparam logic [2:0] OP_LOAD = 3'd3;
  localparam logic [2:0] OP_PORT = 3'd4;

  // RX: data = byte, expv bit0 frame, bit1 parity, bit2 marker
  // PORT: expv bit0 rxFullIrq, bit1 rxErrIrq, bit2 txStart
  typedef struct packed {
    logic [2:0] op;
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] expv;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{OP_RD,   2'd0, 8'h00, 8'h00, 4'd1}, // R1 control reset
    '{OP_RD,   2'd1, 8'h00, 8'h01, 4'd1}, // R1 status reset
    '{OP_RD,   2'd3, 8'h00, 8'h00, 4'd1}, // R1 receive data reset
    '{OP_PORT, 2'd0, 8'h00, 8'h00, 4'd1}, // R1 outputs low
    '{OP_WR,   2'd1, 8'h00, 8'h00, 4'd4}, // R4 clear attempt with txEn 0
    '{OP_RD,   2'd1, 8'h00, 8'h01, 4'd4}, // R4 txEmpty held
    '{OP_WR,   2'd0, 8'h07, 8'h00, 4'd5},
    '{OP_RD,   2'd0, 8'h00, 8'h07, 4'd5},
    '{OP_PORT, 2'd0, 8'h00, 8'h00, 4'd5}, // R5 no start while empty
    '{OP_WR,   2'd2, 8'hA5, 8'h00, 4'd5},
    '{OP_WR,   2'd1, 8'h00, 8'h00, 4'd3}, // R3 armed clear
    '{OP_RD,   2'd1, 8'h00, 8'h00, 4'd3},
    '{OP_PORT, 2'd0, 8'h00, 8'h04, 4'd5}, // R5 start pending
    '{OP_LOAD, 2'd0, 8'h00, 8'h00, 4'd5},
    '{OP_RD,   2'd1, 8'h00, 8'h01, 4'd5}, // R5 load sets txEmpty
    '{OP_PORT, 2'd0, 8'h00, 8'h00, 4'd5},
    '{OP_RX,   2'd0, 8'h3C, 8'h00, 4'd6},
    '{OP_PORT, 2'd0, 8'h00, 8'h01, 4'd2}, // R2 full irq
    '{OP_RD,   2'd3, 8'h00, 8'h3C, 4'd6},
    '{OP_WR,   2'd1, 8'h01, 8'h00, 4'd3}, // R3 write 0 without read
    '{OP_RD,   2'd1, 8'h00, 8'h03, 4'd3},
    '{OP_RX,   2'd0, 8'h77, 8'h00, 4'd7}, // R7 overrun
    '{OP_RD,   2'd1, 8'h00, 8'h13, 4'd7},
    '{OP_RD,   2'd3, 8'h00, 8'h3C, 4'd7},
    '{OP_PORT, 2'd0, 8'h00, 8'h03, 4'd2}, // R2 both irqs
    '{OP_WR,   2'd1, 8'h1F, 8'h00, 4'd3}, // R3 ones change nothing
    '{OP_RD,   2'd1, 8'h00, 8'h13, 4'd3},
    '{OP_WR,   2'd0, 8'h03, 8'h00, 4'd2}, // R2 enable off
    '{OP_PORT, 2'd0, 8'h00, 8'h00, 4'd2},
    '{OP_WR,   2'd0, 8'h01, 8'h00, 4'd8}, // R8 receiver off
    '{OP_RD,   2'd1, 8'h00, 8'h13, 4'd8},
    '{OP_RX,   2'd0, 8'h99, 8'h01, 4'd8},
    '{OP_RD,   2'd1, 8'h00, 8'h13, 4'd8},
    '{OP_RD,   2'd3, 8'h00, 8'h3C, 4'd8},
    '{OP_WR,   2'd1, 8'h01, 8'h00, 4'd3},
    '{OP_RD,   2'd1, 8'h00, 8'h01, 4'd3},
    '{OP_WR,   2'd0, 8'h07, 8'h00, 4'd6},
    '{OP_RX,   2'd0, 8'h5A, 8'h03, 4'd6}, // R6 with errors
    '{OP_RD,   2'd1, 8'h00, 8'h0F, 4'd6},
    '{OP_RD,   2'd3, 8'h00, 8'h5A, 4'd6},
    '{OP_PORT, 2'd0, 8'h00, 8'h03, 4'd2},
    '{OP_WR,   2'd1, 8'h01, 8'h00, 4'd2}, // R2 clear flags
    '{OP_RD,   2'd1, 8'h00, 8'h01, 4'd2},
    '{OP_PORT, 2'd0, 8'h00, 8'h00, 4'd2},
    '{OP_WR,   2'd0, 8'h2F, 8'h00, 4'd9}, // R9 filter on
    '{OP_RX,   2'd0, 8'h11, 8'h00, 4'd9},
    '{OP_RD,   2'd1, 8'h00, 8'h01, 4'd9},
    '{OP_RX,   2'd0, 8'h22, 8'h04, 4'd9},
    '{OP_RD,   2'd0, 8'h00, 8'h27, 4'd9},
    '{OP_RD,   2'd3, 8'h00, 8'h22, 4'd9},
    '{OP_RD,   2'd1, 8'h00, 8'h03, 4'd9},
    '{OP_WR,   2'd1, 8'h01, 8'h00, 4'd9},
    '{OP_WR,   2'd0, 8'h3F, 8'h00, 4'd9}, // R9 clocked mode
    '{OP_RX,   2'd0, 8'h44, 8'h00, 4'd9},
    '{OP_RD,   2'd3, 8'h00, 8'h44, 4'd9},
    '{OP_RD,   2'd1, 8'h00, 8'h03, 4'd9}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic [DATA_W-1:0] txByte;
  logic              txStart;
  logic              txLoad = 1'b0;
  logic              rxValid = 1'b0;
  logic [DATA_W-1:0] rxByte = '0;
  logic              rxFrameErr = 1'b0;
  logic              rxParityErr = 1'b0;
  logic              rxMpBit = 1'b0;
  logic              rxFullIrq;
  logic              rxErrIrq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  serial_ctl_top #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .txByte(txByte), .txStart(txStart), .txLoad(txLoad),
    .rxValid(rxValid), .rxByte(rxByte), .rxFrameErr(rxFrameErr),
    .rxParityErr(rxParityErr), .rxMpBit(rxMpBit),
    .rxFullIrq(rxFullIrq), .rxErrIrq(rxErrIrq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busReadCheck(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 check(req, busRdData, exp);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic portCheck(input logic [7:0] exp, input string req);
    @(negedge clk);
    #1 check(req, {5'd0, txStart, rxErrIrq, rxFullIrq}, exp);
  endtask

  task automatic rxPulse(input logic [7:0] b, input logic [2:0] bits);
    @(negedge clk);
    rxByte = b; rxFrameErr = bits[0]; rxParityErr = bits[1]; rxMpBit = bits[2];
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic loadPulse();
    @(negedge clk);
    txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      case (v.op)
        OP_WR:   busWrite(v.addr, v.data);
        OP_RD:   busReadCheck(v.addr, v.expv, tag);
        OP_RX:   rxPulse(v.data, v.expv[2:0]);
        OP_LOAD: loadPulse();
        default: portCheck(v.expv, tag);
      endcase
    end

    // R5: transmit byte port follows last transmit data write
    @(negedge clk);
    #1 check("R5 txByte", txByte, 8'hA5);

    // R4: turning the transmitter off with a byte pending
    busReadCheck(2'd1, 8'h03, "R4 arm");
    busWrite(2'd1, 8'h02);
    portCheck(8'h05, "R4 start pending");
    busWrite(2'd0, 8'h3E);
    busReadCheck(2'd1, 8'h03, "R4 empty forced");
    portCheck(8'h01, "R4 start dropped");

    // R1: reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    busReadCheck(2'd0, 8'h00, "R1 control after reset");
    busReadCheck(2'd1, 8'h01, "R1 status after reset");
    busReadCheck(2'd3, 8'h00, "R1 data after reset");
    portCheck(8'h00, "R1 outputs after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule